// File: doc/BRIEF.md
# Display Refresh Character Counter

This block keeps track of where a CRT refresh controller is along the current character row. Every refresh bus cycle raises a count enable for one clock, and the counter moves forward by one character position. The counter has two stages. The low stage counts 0 to 15. The high stage is loaded with ten at each row start and takes the low stage's carries. On the fifth carry after a row start, the block emits a single-cycle pulse that marks the 80th character.

When half-width mode is selected, a decode of the combined count finds the 40th character position. The count that moves past that position sets an inhibit, which gates off address transfers for the rest of the row. The next row start clears the inhibit. In full-width mode the inhibit never rises.

At the end of each displayed page, an update pulse loads the low stage with seven. The low stage then walks through a small set of fixed memory positions. Its three lowest bits are driven onto a memory-address bus, but only while the count enable and the control flip-flop state are both high.

Top module: `refresh_char_counter`

## Requirements
- R1: While reset is active and just after it, both stages hold zero, `half_inh` and `row_last` are low, and with `cnt_en` and `ctl_q` high `fa_addr` reads 3'b000.
- R2: In each cycle where `cnt_en` is high and neither preset input is high, the low stage rises by exactly one. When `cnt_en` is low, it holds its value.
- R3: When the low stage steps from 15, it wraps to 0 and passes exactly one carry to the high stage. The high stage changes only on such a carry or on a row start.
- R4: A `row_end` cycle loads the low stage with 0 and the high stage with 10. After exactly 80 further enabled counts, `row_last` is high in the cycle that follows the 80th count.
- R5: `row_end` takes priority over a count and over `page_upd` in the same cycle.
- R6: With `half_mode` high, `half_inh` rises in the cycle after the 40th enabled count following a row start. It stays high until the next `row_end`, which clears it.
- R7: With `half_mode` low, `half_inh` never rises.
- R8: `page_upd` without `row_end` loads the low stage with 7. A count in the same cycle is ignored, and the high stage is unchanged.
- R9: `fa_en` equals `cnt_en` AND `ctl_q`. While `fa_en` is high, `fa_addr` shows bits 2:0 of the low stage. Otherwise `fa_addr` is 3'b000.
- R10: `row_last` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | One-cycle count enable per refresh bus cycle |
| row_end | input | 1 | Row start preset (low stage to 0, high stage to 10) |
| page_upd | input | 1 | End-of-page preset of the low stage to 7 |
| half_mode | input | 1 | Selects 40-column operation |
| ctl_q | input | 1 | State of the control flip-flop that qualifies the address bus |
| row_last | output | 1 | Registered one-cycle pulse at the 80th character |
| half_inh | output | 1 | Address-gating inhibit for the second half of a 40-column row |
| fa_addr | output | 3 | Fixed-position address onto the memory-address bus |
| fa_en | output | 1 | Drive enable for `fa_addr` |

## Verification
The bench counts exactly 80 enabled counts after a row start and expects one pulse in the following cycle. A design that loads the wrong preset, or decodes the wrong high value, would pulse at 64 or 96 counts, and a design that leaves the pulse high would stretch it to two cycles. It also places `row_end` together with `page_upd` and with a count in the same cycle, where a wrong priority would leave the low stage at 7 or 1 instead of 0. In half-width mode it checks that the inhibit rises after the 40th count and not one count early or late, and that in full-width mode the inhibit never rises. A long random mix with gaps between enables checks that idle cycles do not advance the counter and that the address bus stays at zero whenever its enable is low.

// File: rtl/rcc_pkg.sv
package rcc_pkg;
  localparam int LO_W   = 4;
  localparam int HI_W   = 4;
  localparam int ADDR_W = 3;

  typedef logic [LO_W-1:0]   lo_t;
  typedef logic [HI_W-1:0]   hi_t;
  typedef logic [ADDR_W-1:0] fa_t;

  // next value of the low stage on an advance
  function automatic lo_t lo_inc(lo_t v);
    return v + lo_t'(1);
  endfunction

  // low stage about to wrap
  function automatic logic lo_at_top(lo_t v);
    return v == {LO_W{1'b1}};
  endfunction

  function automatic hi_t hi_inc(hi_t v);
    return v + hi_t'(1);
  endfunction

  // combined position compare
  function automatic logic pos_match(hi_t h, lo_t l, hi_t hm, lo_t lm);
    return (h == hm) && (l == lm);
  endfunction

  function automatic fa_t fixed_addr(lo_t l);
    return l[ADDR_W-1:0];
  endfunction
endpackage

// File: rtl/rcc_low_stage.sv
module rcc_low_stage
  import rcc_pkg::*;
#(
  parameter int PAGE_PRESET = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic row_preset,
  input  logic page_preset,
  input  logic step,
  output lo_t  low,
  output logic carry
);
  localparam lo_t PAGE_VAL = lo_t'(PAGE_PRESET);

  logic advance;
  assign advance = step && !row_preset && !page_preset;

  always_ff @(posedge clk) begin
    if (!rst_n)           low <= '0;
    else if (row_preset)  low <= '0;
    else if (page_preset) low <= PAGE_VAL;
    else if (step)        low <= lo_inc(low);
  end

  assign carry = advance && lo_at_top(low);

  assert_row_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    row_preset |=> (low == '0));

  assert_page_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (page_preset && !row_preset) |=> (low == PAGE_VAL));

  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    advance |=> (low == lo_t'($past(low) + 1'b1)));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !row_preset && !page_preset) |=> $stable(low));
endmodule

// File: rtl/rcc_high_stage.sv
module rcc_high_stage
  import rcc_pkg::*;
#(
  parameter int ROW_PRESET = 10,
  parameter int LAST_VAL   = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic row_preset,
  input  logic carry_in,
  output hi_t  high,
  output logic term_q
);
  localparam hi_t PRE_VAL  = hi_t'(ROW_PRESET);
  localparam hi_t LAST_HI  = hi_t'(LAST_VAL);
  localparam hi_t BEFORE   = hi_t'(LAST_VAL - 1);

  logic final_carry;
  assign final_carry = carry_in && (high == BEFORE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      high   <= '0;
      term_q <= 1'b0;
    end else if (row_preset) begin
      high   <= PRE_VAL;
      term_q <= 1'b0;
    end else begin
      if (carry_in) high <= hi_inc(high);
      term_q <= final_carry;
    end
  end

  assert_term_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    term_q |=> !term_q);

  assert_row_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    row_preset |=> (high == PRE_VAL));

  assert_term_at_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    term_q |-> (high == LAST_HI));

  assert_high_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!carry_in && !row_preset) |=> $stable(high));
endmodule

// File: rtl/rcc_half_row.sv
module rcc_half_row
  import rcc_pkg::*;
#(
  parameter int MID_HI = 12,
  parameter int MID_LO = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic row_preset,
  input  logic adv,
  input  logic half_mode,
  input  hi_t  high,
  input  lo_t  low,
  output logic inhibit
);
  logic mid_hit;
  logic set_inh;

  assign mid_hit = pos_match(high, low, hi_t'(MID_HI), lo_t'(MID_LO));
  assign set_inh = adv && half_mode && mid_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)          inhibit <= 1'b0;
    else if (row_preset) inhibit <= 1'b0;
    else if (set_inh)    inhibit <= 1'b1;
  end

  assert_full_mode_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(inhibit) |-> $past(half_mode));

  assert_row_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    row_preset |=> !inhibit);

  assert_inh_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (inhibit && !row_preset) |=> inhibit);
endmodule

// File: rtl/rcc_bus_gate.sv
module rcc_bus_gate
  import rcc_pkg::*;
(
  input  logic cnt_en,
  input  logic ctl_q,
  input  lo_t  low,
  output fa_t  addr,
  output logic bus_en
);
  assign bus_en = cnt_en && ctl_q;
  assign addr   = bus_en ? fixed_addr(low) : '0;

  always_comb begin
    if (!bus_en) assert_gate_idle_R9: assert (addr == '0);
  end
endmodule

// File: rtl/refresh_char_counter.sv
module refresh_char_counter
  import rcc_pkg::*;
#(
  parameter int ROW_PRESET  = 10,
  parameter int ROW_CARRIES = 5,
  parameter int MID_POS     = 40,
  parameter int PAGE_PRESET = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             row_end,
  input  logic             page_upd,
  input  logic             half_mode,
  input  logic             ctl_q,
  output logic             row_last,
  output logic             half_inh,
  output logic [ADDR_W-1:0] fa_addr,
  output logic             fa_en
);
  localparam int LO_SPAN  = 1 << LO_W;
  localparam int LAST_VAL = ROW_PRESET + ROW_CARRIES;
  localparam int MID_IDX  = MID_POS - 1;
  localparam int MID_HI   = ROW_PRESET + MID_IDX / LO_SPAN;
  localparam int MID_LO   = MID_IDX % LO_SPAN;

  lo_t  low;
  hi_t  high;
  logic carry;
  logic adv;

  assign adv = cnt_en && !row_end && !page_upd;

  rcc_low_stage #(.PAGE_PRESET(PAGE_PRESET)) u_low (
    .clk(clk), .rst_n(rst_n), .row_preset(row_end), .page_preset(page_upd),
    .step(cnt_en), .low(low), .carry(carry)
  );

  rcc_high_stage #(.ROW_PRESET(ROW_PRESET), .LAST_VAL(LAST_VAL)) u_high (
    .clk(clk), .rst_n(rst_n), .row_preset(row_end), .carry_in(carry),
    .high(high), .term_q(row_last)
  );

  rcc_half_row #(.MID_HI(MID_HI), .MID_LO(MID_LO)) u_half (
    .clk(clk), .rst_n(rst_n), .row_preset(row_end), .adv(adv),
    .half_mode(half_mode), .high(high), .low(low), .inhibit(half_inh)
  );

  rcc_bus_gate u_gate (
    .cnt_en(cnt_en), .ctl_q(ctl_q), .low(low), .addr(fa_addr), .bus_en(fa_en)
  );

  assert_carry_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    carry |=> (low == '0));

  assert_row_beats_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (row_end && page_upd) |=> (low == '0 && !row_last));
endmodule

// File: tb/refresh_char_counter_bench.sv
module refresh_char_counter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 1'b0, row_end = 1'b0, page_upd = 1'b0, half_mode = 1'b0, ctl_q = 1'b0;
  logic row_last, half_inh, fa_en;
  logic [2:0] fa_addr;

  always #4 clk = ~clk;

  refresh_char_counter u_refresh_char_counter (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .row_end(row_end),
    .page_upd(page_upd), .half_mode(half_mode), .ctl_q(ctl_q),
    .row_last(row_last), .half_inh(half_inh), .fa_addr(fa_addr), .fa_en(fa_en)
  );

  typedef struct {
    logic       en;
    logic [2:0] addr;
    logic       inh;
    logic       term;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference: combined count v = high*16 + low
  logic [7:0] v = 8'd0;
  logic m_inh = 1'b0, m_term = 1'b0;

  task automatic step(input logic en, input logic re, input logic pu,
                      input logic hm, input logic cq, input string tag);
    exp_t e;
    @(negedge clk);
    cnt_en = en; row_end = re; page_upd = pu; half_mode = hm; ctl_q = cq;
    e.en   = en & cq;
    e.addr = (en & cq) ? v[2:0] : 3'b000;
    e.inh  = m_inh;
    e.term = m_term;
    e.tag  = tag;
    sb.push_back(e);
    if (re) begin
      v = 8'd160; m_inh = 1'b0; m_term = 1'b0;
    end else if (pu) begin
      v = {v[7:4], 4'd7}; m_term = 1'b0;
    end else if (en) begin
      m_term = (v == 8'd239);
      if (hm && v == 8'd199) m_inh = 1'b1;
      v = v + 8'd1;
    end else begin
      m_term = 1'b0;
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #2;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (fa_en !== e.en || fa_addr !== e.addr || half_inh !== e.inh || row_last !== e.term) begin
          errors++;
          $display("FAIL %s: got en=%b addr=%0d inh=%b last=%b, expected en=%b addr=%0d inh=%b last=%b",
                   e.tag, fa_en, fa_addr, half_inh, row_last, e.en, e.addr, e.inh, e.term);
        end
      end
    end
  end

  initial begin : watchdog
    #1600000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : driver
    int pulses;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (row_last !== 1'b0 || half_inh !== 1'b0) begin
      errors++;
      $display("FAIL R1: got last=%b inh=%b, expected 0 0", row_last, half_inh);
    end
    @(negedge clk); rst_n = 1'b1;
    step(1, 0, 0, 0, 1, "R1");
    // R9: gating
    step(1, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 1, "R9");
    step(0, 0, 0, 0, 0, "R9");
    // R2: counts with gaps
    for (int i = 0; i < 20; i++) step(1, 0, 0, 0, 1, "R2");
    for (int i = 0; i < 6; i++) begin
      step(0, 0, 0, 0, 1, "R2");
      step(1, 0, 0, 0, 1, "R2");
    end
    // R4 R3 R10 R7: full row, full-width mode
    step(0, 1, 0, 0, 1, "R4");
    for (int i = 0; i < 85; i++) step(1, 0, 0, 0, 1, "R4_R3_R10_R7");
    // independent pulse-count check for R4
    step(0, 1, 0, 0, 1, "R4");
    pulses = 0;
    for (int i = 0; i < 80; i++) begin
      step(1, 0, 0, 0, 1, "R4");
      #3;
      if (row_last) pulses++;
    end
    step(0, 0, 0, 0, 1, "R4");
    #3;
    checks++;
    if (row_last !== 1'b1 || pulses != 0) begin
      errors++;
      $display("FAIL R4: got last=%b early=%0d, expected 1 0", row_last, pulses);
    end
    // R6: half mode
    step(0, 1, 0, 1, 1, "R6");
    for (int i = 0; i < 90; i++) step(1, 0, 0, 1, 1, "R6");
    step(0, 0, 0, 1, 1, "R6");
    step(0, 1, 0, 1, 1, "R6");
    step(0, 0, 0, 1, 1, "R6");
    for (int i = 0; i < 45; i++) step(i % 3 != 0, 0, 0, 1, 1, "R6");
    // R5: priority of row start
    step(1, 1, 1, 1, 1, "R5");
    step(1, 0, 0, 1, 1, "R5");
    step(1, 1, 0, 0, 1, "R5");
    step(0, 1, 1, 0, 1, "R5");
    step(1, 0, 0, 0, 1, "R5");
    // R8: page update
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 1, "R8");
    step(1, 0, 1, 0, 1, "R8");
    for (int i = 0; i < 10; i++) step(1, 0, 0, 0, 1, "R8");
    step(0, 0, 1, 0, 1, "R8");
    step(1, 0, 0, 0, 1, "R8");
    // random mix
    for (int i = 0; i < 2000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      step(r < 70, r == 99 || r == 98, r == 97, i > 1000, r[0] | (r > 30), "R2_R9_mix");
    end
    repeat (3) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule